// File: doc/BRIEF.md
# Prioritizing Interrupt Controller

This block collects `N_SRC` interrupt request lines and drives a processor's normal (`irq_o`) and fast (`fiq_o`) interrupt inputs. Requests are latched into a multi-bit source-pending register. One source at a time may be designated fast. A pending fast source drives `fiq_o` directly, and the mask and priority logic play no part in it. The other pending sources pass through a mask. The survivors are arbitrated in a fixed order, and the winner is moved into a one-hot in-service register. `irq_o` is asserted while that register is non-zero.

Software reaches the registers through a single-cycle port with an address, write data, a write enable and combinational read data. A handler reads the offset register to find the in-service index. It then clears that source's bit in the source-pending register and afterwards clears the in-service bit. When the in-service register empties, the next winner is loaded at the same clock edge. If the handled source's pending bit was left set, that source can win again.

Register select (`addr_i`): 0 = source pending (read, write-1-to-clear), 1 = fast select (read/write), 2 = mask (read/write, 1 blocks), 3 = in-service (read, write-1-to-clear), 4 = offset (read only). Any other address reads as zero and ignores writes.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A high bit on `req_i` at a clock edge sets the matching source-pending bit, which then stays set until software clears it. Several bits may be set together.
- R2: Writing to address 0 clears each source-pending bit whose write-data bit is 1. If a request arrives at the same edge, the set wins.
- R3: A write to address 1 keeps only the lowest-indexed 1 of the write data. The fast-select register therefore never holds more than one set bit.
- R4: `fiq_o` is high whenever a source-pending bit is set together with its fast-select bit. This holds whatever the mask and in-service state are.
- R5: A source that is masked (mask bit 1) or marked fast is never loaded into the in-service register.
- R6: The in-service register holds at most one set bit. When it is empty, it loads at the next edge the lowest-indexed pending source that is unmasked and not fast. A non-empty in-service register is not replaced by a higher-priority arrival.
- R7: `irq_o` is high exactly when the in-service register is non-zero.
- R8: Writing to address 3 clears the in-service bits whose write-data bit is 1. A 1 written to a bit that is not set has no effect. If the register becomes empty, the next winner is loaded at that same edge.
- R9: `svc_idx_o`, and a read of address 4, return the binary index of the in-service bit, or 0 when no bit is in service.
- R10: After reset, the pending, fast-select and in-service registers are zero and the mask register is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_SRC | Interrupt request lines |
| addr_i | input | 3 | Register select |
| wdata_i | input | N_SRC | Write data |
| we_i | input | 1 | Write enable |
| rdata_o | output | N_SRC | Read data for `addr_i` |
| fiq_o | output | 1 | Fast interrupt line |
| irq_o | output | 1 | Normal interrupt line |
| svc_idx_o | output | $clog2(N_SRC) | Index of the in-service source |

## Verification
The assertions assume that `req_i`, `we_i`, `addr_i` and `wdata_i` carry known values at every clock edge after reset. They also assume that writes are single-cycle and fully decoded by `addr_i`. The stimulus always drives defined values, changes them only at the falling edge, and includes addresses outside the map. Random write data deliberately loads the fast-select register with several bits at once and writes 1s to in-service bits that are not set. These cover the cases that the assertions on R3 and R8 rely on.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  typedef enum logic [2:0] {
    SEL_PEND = 3'd0,
    SEL_FAST = 3'd1,
    SEL_MASK = 3'd2,
    SEL_SVC  = 3'd3,
    SEL_OFFS = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/prio_pick.sv
// Fixed priority: lowest index wins, one-hot grant.
module prio_pick #(
  parameter int W = 8
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] gnt_o
);
  logic found;
  always_comb begin
    gnt_o = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (req_i[i] && !found) begin
        gnt_o[i] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/onehot_idx.sv
module onehot_idx #(
  parameter int W  = 8,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  onehot_i,
  output logic [IW-1:0] idx_o
);
  for (genvar b = 0; b < IW; b++) begin : g_bit
    logic [W-1:0] sel;
    for (genvar i = 0; i < W; i++) begin : g_src
      assign sel[i] = onehot_i[i] & ((i >> b) & 1) == 1;
    end
    assign idx_o[b] = |sel;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int IW = $clog2(N_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] req_i,
  input  logic [2:0]       addr_i,
  input  logic [N_SRC-1:0] wdata_i,
  input  logic             we_i,
  output logic [N_SRC-1:0] rdata_o,
  output logic             fiq_o,
  output logic             irq_o,
  output logic [IW-1:0]    svc_idx_o
);
  logic [N_SRC-1:0] src_q, mode_q, mask_q, svc_q;
  logic [N_SRC-1:0] src_clr, svc_clr, svc_left, svc_d;
  logic [N_SRC-1:0] cand, win, mode_keep;
  logic             wr_pend, wr_fast, wr_mask, wr_svc;

  assign wr_pend = we_i && (addr_i == SEL_PEND);
  assign wr_fast = we_i && (addr_i == SEL_FAST);
  assign wr_mask = we_i && (addr_i == SEL_MASK);
  assign wr_svc  = we_i && (addr_i == SEL_SVC);

  assign src_clr = wr_pend ? wdata_i : '0;
  assign svc_clr = wr_svc  ? wdata_i : '0;

  // fast sources bypass mask and arbitration
  assign cand = src_q & ~mode_q & ~mask_q;

  prio_pick #(.W(N_SRC)) u_arb  (.req_i(cand),    .gnt_o(win));
  prio_pick #(.W(N_SRC)) u_fsel (.req_i(wdata_i), .gnt_o(mode_keep));
  onehot_idx #(.W(N_SRC)) u_enc (.onehot_i(svc_q), .idx_o(svc_idx_o));

  always_comb begin
    svc_left = svc_q & ~svc_clr;
    svc_d    = (svc_left == '0) ? win : svc_left;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      mode_q <= '0;
      mask_q <= '1;
      svc_q  <= '0;
    end else begin
      src_q <= (src_q & ~src_clr) | req_i;
      if (wr_fast) mode_q <= mode_keep;
      if (wr_mask) mask_q <= wdata_i;
      svc_q <= svc_d;
    end
  end

  assign fiq_o = |(src_q & mode_q);
  assign irq_o = |svc_q;

  always_comb begin
    unique case (addr_i)
      SEL_PEND: rdata_o = src_q;
      SEL_FAST: rdata_o = mode_q;
      SEL_MASK: rdata_o = mask_q;
      SEL_SVC:  rdata_o = svc_q;
      SEL_OFFS: rdata_o = N_SRC'(svc_idx_o);
      default:  rdata_o = '0;
    endcase
  end

  // R1
  src_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |=> ((src_q & $past(req_i)) == $past(req_i)));

  // R3
  fast_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mode_q));

  // R5
  svc_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_q == '0) |=> ((svc_q & $past(mode_q | mask_q)) == '0));

  // R6
  svc_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(svc_q));

  // R6
  svc_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (svc_q == '0 && cand != '0) |=> (svc_q != '0));

  // R8
  svc_noop_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_svc && svc_q != '0 && (wdata_i & svc_q) == '0) |=> $stable(svc_q));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int N  = 8;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] req = '0, wd = '0, rd;
  logic [2:0] addr = 3'd0;
  logic we = 1'b0;
  logic fiq, irq;
  logic [IW-1:0] idx;
  int tests = 0, fails = 0;
  bit done = 0;

  logic [N-1:0] m_src, m_mode, m_mask, m_svc;

  always #4 clk = ~clk;

  prio_irq_ctrl #(.N_SRC(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .addr_i(addr),
    .wdata_i(wd), .we_i(we), .rdata_o(rd), .fiq_o(fiq), .irq_o(irq),
    .svc_idx_o(idx)
  );

  function automatic logic [N-1:0] low1(input logic [N-1:0] x);
    return x & (~x + 1'b1);
  endfunction

  function automatic int idx_of(input logic [N-1:0] x);
    for (int i = 0; i < N; i++) if (x[i]) return i;
    return 0;
  endfunction

  function automatic logic [N-1:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_src;
      3'd1: return m_mode;
      3'd2: return m_mask;
      3'd3: return m_svc;
      3'd4: return N'(idx_of(m_svc));
      default: return '0;
    endcase
  endfunction

  // reference model, updated from the requirements
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_src = '0; m_mode = '0; m_mask = '1; m_svc = '0;
    end else begin
      logic [N-1:0] t, c;
      c = low1(m_src & ~m_mode & ~m_mask);
      t = m_svc & ~((we && addr == 3'd3) ? wd : '0);
      m_svc = (t == '0) ? c : t;
      m_src = (m_src & ~((we && addr == 3'd0) ? wd : '0)) | req;
      if (we && addr == 3'd1) m_mode = low1(wd);
      if (we && addr == 3'd2) m_mask = wd;
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic check_all();
    chk("R7", int'(irq), int'(m_svc != '0));
    chk("R4", int'(fiq), int'((m_src & m_mode) != '0));
    chk("R9", int'(idx), idx_of(m_svc));
    case (addr)
      3'd0: chk("R1", int'(rd), int'(exp_rd(addr)));
      3'd1: chk("R3", int'(rd), int'(exp_rd(addr)));
      3'd2: chk("R5", int'(rd), int'(exp_rd(addr)));
      3'd3: chk("R6", int'(rd), int'(exp_rd(addr)));
      default: chk("R9", int'(rd), int'(exp_rd(addr)));
    endcase
  endtask

  task automatic step(input logic [N-1:0] r, input logic w,
                      input logic [2:0] a, input logic [N-1:0] d);
    req = r; we = w; addr = a; wd = d;
    @(negedge clk);
    check_all();
  endtask

  initial begin
    logic [N-1:0] keep;
    void'($urandom(32'h5eed));
    m_src = '0; m_mode = '0; m_mask = '1; m_svc = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    addr = 3'd2;
    #1;
    // R10 reset state
    chk("R10", int'(rd), int'(8'hFF));
    chk("R10", int'(irq), 0);
    chk("R10", int'(fiq), 0);
    @(negedge clk);

    // R3 multi-bit fast select keeps lowest
    step('0, 1'b1, 3'd1, 8'b0110_1000);
    chk("R3", int'(rd), int'(8'b0000_1000));
    // R4 fast source drives fiq while still masked
    step(8'h08, 1'b0, 3'd0, '0);
    chk("R4", int'(fiq), 1);
    // R5 unmask all: fast source must not reach in-service
    step('0, 1'b1, 3'd2, 8'h00);
    step('0, 1'b0, 3'd3, '0);
    chk("R5", int'(irq), 0);
    // mask bit0, raise bits 0 and 5
    step('0, 1'b1, 3'd2, 8'h01);
    step(8'h21, 1'b0, 3'd3, '0);
    step('0, 1'b0, 3'd3, '0);
    chk("R6", int'(rd), int'(8'h20));
    chk("R5", int'(rd & 8'h01), 0);
    chk("R9", int'(idx), 5);
    // R8 clearing an unset bit has no effect
    step('0, 1'b1, 3'd3, 8'h01);
    chk("R8", int'(rd), int'(8'h20));
    // R6 higher-priority arrival does not replace
    step(8'h02, 1'b0, 3'd3, '0);
    step('0, 1'b0, 3'd3, '0);
    chk("R6", int'(rd), int'(8'h20));
    // R8 clear in-service: bit1 wins at once
    step('0, 1'b1, 3'd3, 8'h20);
    chk("R8", int'(rd), int'(8'h02));
    // clear pend bit1, then in-service: bit5 reselected (pend left set)
    step('0, 1'b1, 3'd0, 8'h02);
    step('0, 1'b1, 3'd3, 8'h02);
    chk("R8", int'(rd), int'(8'h20));
    step('0, 1'b0, 3'd4, '0);
    chk("R9", int'(rd), 5);
    // R2 set wins over clear at same edge
    step(8'h04, 1'b1, 3'd0, 8'h04);
    chk("R2", int'(rd & 8'h04), int'(8'h04));
    // R2 plain clear
    step('0, 1'b1, 3'd0, 8'h04);
    chk("R2", int'(rd & 8'h04), 0);
    // R1 several bits latch and hold
    step(8'hC0, 1'b0, 3'd0, '0);
    step('0, 1'b0, 3'd0, '0);
    chk("R1", int'(rd & 8'hC0), int'(8'hC0));

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [N-1:0] r, d;
      logic [2:0] a;
      r = N'($urandom & $urandom & $urandom);
      a = 3'($urandom_range(0, 5));
      d = N'($urandom);
      if (a == 3'd3 && ($urandom & 1)) d = m_svc;
      keep = m_svc;
      step(r, 1'($urandom_range(0, 1)), a, d);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule